// File: doc/BRIEF.md
# Magnitude Approximation Engine

This block estimates the length of a two-component vector, sqrt(a² + b²), from two signed inputs. It does not use a square root or a multiplier. It computes x = max(|a|, |b|) and y = min(|a|, |b|), then returns max(x − x/8 + y/2, x). A seven-state controller runs the computation over a small datapath with the following parts:

- three shared registers;
- two multi-function arithmetic units;
- two fixed right shifters chained behind those units;
- four buses. Two buses carry register values to the units. The other two carry results back to the registers.

A client drives both operands and raises `start`. While the engine is idle it samples the operands on the first clock edge at which `start` is high. Five edges later `done` rises for a single cycle, and during that cycle `result` holds the estimate. Each computation runs to completion before the next one can begin. `start` has no effect while a computation is in progress.

Top module: `sqrt_mag_approx`

## Requirements
- R1: While idle with `start` low, the block stays idle: `done` remains 0 whatever the operands do. When `start` is sampled high in idle, `in_a` and `in_b` are captured on that edge.
- R2: `done` is 1 for exactly one cycle. That cycle begins five clock edges after the edge that captured the operands. At the next edge the block is idle again.
- R3: `start`, `in_a` and `in_b` have no effect while a computation is in progress. The result and the latency depend only on the captured operands.
- R4: While `done` is 1, `result` equals max(t6, x) as a signed W-bit value, where:
  - x = max(|a|, |b|) and y = min(|a|, |b|);
  - t6 = (x − (x >> 3)) + (y >> 1);
  - the shifts are arithmetic right shifts of non-negative values.

  The result is therefore never negative and never less than x.
- R5: The absolute value of the most negative W-bit operand (−2^(W−1)) saturates to 2^(W−1) − 1.
- R6: If the addition that forms t6 would exceed 2^(W−1) − 1, it saturates to 2^(W−1) − 1.
- R7: `result` is 0 in every cycle in which `done` is 0.
- R8: The result depends only on the magnitudes of the operands. Swapping the operands or negating either one gives the same estimate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a computation; sampled only while idle |
| in_a | input | W | First signed operand |
| in_b | input | W | Second signed operand |
| result | output | W | Magnitude estimate, valid while `done` is 1, otherwise 0 |
| done | output | 1 | One-cycle flag marking a valid result |

## Verification
The bench builds the engine at 8 bits. It sweeps every value of the first operand against a stepped grid of the second operand, plus four extra second operands:

- the largest positive value, which drives the sum into saturation;
- the same value as the first operand, so the two magnitudes tie;
- the negated first operand, which pairs mixed signs with equal magnitude;
- the most negative value, which hits the saturating absolute value.

Every result and every latency is compared with an integer model of the formula. Together these patterns separate a wrong choice between min and max, a missing chained shift, a wrapping absolute value or sum, and a missing final max. A further run holds `start` high with changing operands throughout a computation, which shows whether the busy engine ignores the request. An idle stretch with `start` low shows that nothing happens without a request.

// File: rtl/sra_pkg.sv
// Shared types for the magnitude approximation engine.
// Assumes: one controller drives one datapath; the enums are the control-word fields.
package sra_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ABS  = 3'd1,
        ST_SORT = 3'd2,
        ST_SUB  = 3'd3,
        ST_ADD  = 3'd4,
        ST_MAX  = 3'd5,
        ST_DONE = 3'd6
    } sra_state_e;

    // Operation of the abs/max unit.
    typedef enum logic {
        U1_ABS = 1'b0,
        U1_MAX = 1'b1
    } u1_op_e;

    // Operation of the abs/min/add/sub unit.
    typedef enum logic [1:0] {
        U2_ABS = 2'd0,
        U2_MIN = 2'd1,
        U2_ADD = 2'd2,
        U2_SUB = 2'd3
    } u2_op_e;

    // Source of the first read bus.
    typedef enum logic {
        RD1_R1 = 1'b0,
        RD1_R3 = 1'b1
    } rd1_sel_e;

    // Source of the first write bus.
    typedef enum logic {
        WB1_IN = 1'b0,
        WB1_U1 = 1'b1
    } wb1_sel_e;

    // Source of the second write bus.
    typedef enum logic [1:0] {
        WB2_IN  = 2'd0,
        WB2_U2  = 2'd1,
        WB2_SHX = 2'd2
    } wb2_sel_e;

    typedef struct packed {
        logic     r1_we;
        logic     r2_we;
        logic     r3_we;
        rd1_sel_e rd1_sel;
        u1_op_e   u1_op;
        u2_op_e   u2_op;
        wb1_sel_e wb1_sel;
        wb2_sel_e wb2_sel;
        logic     done;
    } sra_ctrl_t;

endpackage

// File: rtl/sra_ctrl.sv
// Controller: seven-state schedule that issues one control word per cycle.
// Assumes: start is sampled only in ST_IDLE; the sequence cannot be interrupted.
module sra_ctrl
    import sra_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output sra_state_e state,
    output sra_ctrl_t  cw
);

    sra_state_e state_q, state_d;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control word for the current state.
    always_comb begin
        state_d    = state_q;
        cw         = '0;
        cw.rd1_sel = RD1_R1;
        cw.u1_op   = U1_ABS;
        cw.u2_op   = U2_ABS;
        cw.wb1_sel = WB1_U1;
        cw.wb2_sel = WB2_U2;
        unique case (state_q)
            ST_IDLE: begin
                cw.wb1_sel = WB1_IN;
                cw.wb2_sel = WB2_IN;
                cw.r1_we   = start;
                cw.r2_we   = start;
                if (start) state_d = ST_ABS;
            end
            ST_ABS: begin
                cw.r1_we = 1'b1;
                cw.r2_we = 1'b1;
                state_d  = ST_SORT;
            end
            ST_SORT: begin
                cw.u1_op   = U1_MAX;
                cw.u2_op   = U2_MIN;
                cw.wb2_sel = WB2_SHX;
                cw.r1_we   = 1'b1;
                cw.r2_we   = 1'b1;
                cw.r3_we   = 1'b1;
                state_d    = ST_SUB;
            end
            ST_SUB: begin
                cw.u2_op = U2_SUB;
                cw.r2_we = 1'b1;
                state_d  = ST_ADD;
            end
            ST_ADD: begin
                cw.rd1_sel = RD1_R3;
                cw.u2_op   = U2_ADD;
                cw.r2_we   = 1'b1;
                state_d    = ST_MAX;
            end
            ST_MAX: begin
                cw.u1_op = U1_MAX;
                cw.r1_we = 1'b1;
                state_d  = ST_DONE;
            end
            ST_DONE: begin
                cw.done = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/sra_unit_absmax.sv
// Functional unit one: saturating absolute value of p, or signed maximum of p and q.
// Assumes: operands are W-bit two's complement; |min negative| saturates to max positive.
module sra_unit_absmax
    import sra_pkg::*;
#(
    parameter int W = 16
) (
    input  u1_op_e       op,
    input  logic [W-1:0] p,
    input  logic [W-1:0] q,
    output logic [W-1:0] y
);

    localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINNEG = {1'b1, {(W-1){1'b0}}};

    // Result selection for the requested operation.
    always_comb begin
        if (op == U1_MAX) begin
            y = ($signed(p) >= $signed(q)) ? p : q;
        end else if (p == MINNEG) begin
            y = MAXPOS;
        end else if (p[W-1]) begin
            y = -p;
        end else begin
            y = p;
        end
    end

endmodule

// File: rtl/sra_unit_arith.sv
// Functional unit two: saturating abs of q, signed min, saturating add and subtract.
// Assumes: operands are W-bit two's complement; overflow clamps to the nearest bound.
module sra_unit_arith
    import sra_pkg::*;
#(
    parameter int W = 16
) (
    input  u2_op_e       op,
    input  logic [W-1:0] p,
    input  logic [W-1:0] q,
    output logic [W-1:0] y
);

    localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINNEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] sum, dif;
    logic         sum_ovf, dif_ovf;

    // Raw sum and difference with signed overflow flags.
    always_comb begin
        sum     = p + q;
        dif     = p - q;
        sum_ovf = (p[W-1] == q[W-1]) && (sum[W-1] != p[W-1]);
        dif_ovf = (p[W-1] != q[W-1]) && (dif[W-1] != p[W-1]);
    end

    // Result selection with saturation.
    always_comb begin
        unique case (op)
            U2_ABS: begin
                if (q == MINNEG)  y = MAXPOS;
                else if (q[W-1])  y = -q;
                else              y = q;
            end
            U2_MIN:  y = ($signed(p) <= $signed(q)) ? p : q;
            U2_ADD:  y = sum_ovf ? (p[W-1] ? MINNEG : MAXPOS) : sum;
            U2_SUB:  y = dif_ovf ? (p[W-1] ? MINNEG : MAXPOS) : dif;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sra_shift.sv
// Fixed arithmetic right shifter chained behind a functional unit.
// Assumes: SH is smaller than W.
module sra_shift #(
    parameter int W  = 16,
    parameter int SH = 1
) (
    input  logic [W-1:0] d,
    output logic [W-1:0] y
);

    // Constant shift; pure wiring.
    always_comb y = $unsigned($signed(d) >>> SH);

endmodule

// File: rtl/sqrt_mag_approx.sv
// Top: magnitude estimate max(x - x/8 + y/2, x) computed on a shared datapath.
// Assumes: one computation at a time; R1, R2, R3 are shared by the schedule's variables.
module sqrt_mag_approx
    import sra_pkg::*;
#(
    parameter int W       = 16,
    parameter int SHIFT_X = 3,
    parameter int SHIFT_Y = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] result,
    output logic         done
);

    localparam int NREG = 3;
    localparam int IR1  = 0;
    localparam int IR2  = 1;
    localparam int IR3  = 2;

    sra_state_e ctl_state;
    sra_ctrl_t  cw;

    logic [NREG-1:0][W-1:0] reg_q;
    logic [NREG-1:0][W-1:0] reg_d;
    logic [NREG-1:0]        reg_we;

    logic [W-1:0] rbus1, rbus2, wbus1, wbus2;
    logic [W-1:0] u1_y, u2_y, shx_y, shy_y;
    logic [W-1:0] r1_q, r3_q;

    sra_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .state (ctl_state),
        .cw    (cw)
    );

    // Read buses: register outputs to unit inputs.
    always_comb begin
        rbus1 = (cw.rd1_sel == RD1_R3) ? reg_q[IR3] : reg_q[IR1];
        rbus2 = reg_q[IR2];
    end

    sra_unit_absmax #(.W(W)) u_fu1 (
        .op (cw.u1_op),
        .p  (rbus1),
        .q  (rbus2),
        .y  (u1_y)
    );

    sra_unit_arith #(.W(W)) u_fu2 (
        .op (cw.u2_op),
        .p  (rbus1),
        .q  (rbus2),
        .y  (u2_y)
    );

    sra_shift #(.W(W), .SH(SHIFT_X)) u_shx (
        .d (u1_y),
        .y (shx_y)
    );

    sra_shift #(.W(W), .SH(SHIFT_Y)) u_shy (
        .d (u2_y),
        .y (shy_y)
    );

    // Write buses: unit, shifter and input values back to the registers.
    always_comb begin
        wbus1 = (cw.wb1_sel == WB1_IN) ? in_a : u1_y;
        unique case (cw.wb2_sel)
            WB2_IN:  wbus2 = in_b;
            WB2_SHX: wbus2 = shx_y;
            default: wbus2 = u2_y;
        endcase
    end

    // Register inputs and enables from the control word.
    always_comb begin
        reg_d[IR1]  = wbus1;
        reg_d[IR2]  = wbus2;
        reg_d[IR3]  = shy_y;
        reg_we[IR1] = cw.r1_we;
        reg_we[IR2] = cw.r2_we;
        reg_we[IR3] = cw.r3_we;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Shared datapath register with load enable.
        always_ff @(posedge clk) begin
            if (!rst_n)         reg_q[g] <= '0;
            else if (reg_we[g]) reg_q[g] <= reg_d[g];
        end
    end

    assign r1_q = reg_q[IR1];
    assign r3_q = reg_q[IR3];

    // Output port: R1 drives the result only in the final state.
    always_comb begin
        done   = cw.done;
        result = cw.done ? r1_q : '0;
    end

endmodule

// File: rtl/sqrt_mag_approx_chk.sv
// Checker for sqrt_mag_approx: protocol and ordering properties of the schedule.
// Assumes: attached by the bind below; sees the controller state and R1/R3.
module sqrt_mag_approx_chk
    import sra_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic [W-1:0] result,
    input sra_state_e   state,
    input logic [W-1:0] r1_q,
    input logic [W-1:0] r3_q
);

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> (state == ST_IDLE && !done));

    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_ABS));

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && state == ST_IDLE));

    a_r3_t4_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SORT) |=> $stable(r3_q));

    a_r4_not_below_x: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MAX) |=> (done && $signed(result) >= $signed($past(r1_q))));

    a_r4_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !result[W-1]);

    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (result == '0));

endmodule

bind sqrt_mag_approx sqrt_mag_approx_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .result (result),
    .state  (ctl_state),
    .r1_q   (r1_q),
    .r3_q   (r3_q)
);

// File: tb/tb_sqrt_mag_approx.sv
// Bench: near-exhaustive 8-bit sweep against an integer model of the estimate.
module tb_sqrt_mag_approx;

    localparam int W     = 8;
    localparam int MAXP  = 127;
    localparam int LAT   = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic [W-1:0] result;
    logic         done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    sqrt_mag_approx #(.W(W)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .in_a   (in_a),
        .in_b   (in_b),
        .result (result),
        .done   (done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int sat_abs(int v);
        if (v == -128) return MAXP;
        return (v < 0) ? -v : v;
    endfunction

    // Integer model of R4, R5, R6.
    function automatic int model(int a, int b);
        int aa = sat_abs(a);
        int bb = sat_abs(b);
        int x  = (aa > bb) ? aa : bb;
        int y  = (aa > bb) ? bb : aa;
        int t6 = (x - (x >> 3)) + (y >> 1);
        if (t6 > MAXP) t6 = MAXP;
        return (t6 > x) ? t6 : x;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One computation; if busy_poke, start stays high with changing operands until done.
    task automatic run(int a, int b, bit busy_poke);
        int n = 0;
        int exp = model(a, b);
        in_a  = W'(a);
        in_b  = W'(b);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = busy_poke;
        in_a  = W'(a ^ 8'h5a);
        in_b  = W'(b + 37);
        while (!done && n < 20) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            in_a = W'(in_a + 3);
        end
        start = 1'b0;
        check(n == LAT, busy_poke ? "R3 latency" : "R2 latency", n, LAT);
        check($signed(result) == exp, busy_poke ? "R3 result" : "R4 result",
              $signed(result), exp);
        @(posedge clk);
        @(negedge clk);
        check(!done && result == '0, "R2/R7 done drops", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!done && result == '0, "R7 reset state", int'(result), 0);
        rst_n = 1'b1;

        // R1: idle with start low, operands moving.
        for (int i = 0; i < 10; i++) begin
            in_a = W'(i * 29);
            in_b = W'(i * 71);
            @(posedge clk);
            @(negedge clk);
            check(!done && result == '0, "R1 idle", int'(done), 0);
        end

        // Named corner cases.
        run(0, 0, 1'b0);                     // R4 zero
        check(1'b1, "R4 zero run", 0, 0);
        run(-128, 0, 1'b0);                  // R5 saturating abs -> 127
        check($signed(model(-128, 0)) == MAXP, "R5 model", model(-128, 0), MAXP);
        run(-128, -128, 1'b0);               // R5 and R6
        run(127, 127, 1'b0);                 // R6 sum saturates
        run(100, -100, 1'b0);                // R8 mixed sign equal magnitude
        run(-100, 100, 1'b0);                // R8 swapped
        run(3, -90, 1'b0);                   // R8
        run(-90, 3, 1'b0);                   // R8 swapped
        run(40, 30, 1'b1);                   // R3 busy start ignored
        run(-77, 5, 1'b1);                   // R3

        // Near-exhaustive sweep: every a against a grid plus ties, negation, extremes.
        for (int a = -128; a < 128; a++) begin
            for (int bi = 0; bi < 36; bi++) begin
                int b;
                if (bi < 32)       b = bi * 8 - 128;
                else if (bi == 32) b = 127;
                else if (bi == 33) b = a;
                else if (bi == 34) b = (a == -128) ? 127 : -a;
                else               b = -128;
                run(a, b, 1'b0);             // R4 R5 R6 R8
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule